// File: doc/BRIEF.md
# Serial Panel Power-Up Sequencer

This block brings a serially controlled TFT panel from power-on to a lit display with no software involvement. A single start pulse begins the run. The block holds the panel's active-low reset line low, releases it and lets the panel settle. It then frames and shifts a fixed script of command and parameter bytes over a write-only SPI link, and inserts the long wake-up delay that the panel requires. When the last command byte has left the shifter, the block raises a done flag and keeps it high until its own reset.

The script sends four bytes. The first is the wake command. After the wake delay comes the pixel-format command with its parameter, and the display-on command comes last. The parameter picks 16-bit or 18-bit colour from a static input. The input is sampled when the start pulse is accepted. All delays are counted in system-clock cycles, worked out from a clock-frequency parameter and a millisecond length for each delay. A scale parameter can shorten every delay for quick runs. The serial clock is the system clock divided by twice a half-period parameter. That parameter must be chosen so that the serial clock stays at or below 20 MHz.

Top module: `panel_init_seq`

## Requirements
- R1: While `rst_n` is low and right after it is released, `panel_rst_n_o`=1, `cs_n_o`=1, `sck_o`=0, `busy_o`=0 and `done_o`=0.
- R2: After an accepted start, `panel_rst_n_o` stays low for between RST_CYC and RST_CYC+2 cycles, with RST_CYC = RST_MS·CLK_HZ/1000/DLY_SCALE. It then goes high, and `cs_n_o` stays high for at least POST_CYC further cycles.
- R3: Exactly four bytes are shifted per run, in this order: 0x11 with `dc_o`=0, 0x3A with `dc_o`=0, the format parameter with `dc_o`=1, and 0x29 with `dc_o`=0.
- R4: The format parameter is 0x55 when `fmt18_i`=0 and 0x66 when `fmt18_i`=1, taken as sampled in the start cycle. Later changes of `fmt18_i` have no effect.
- R5: At least WAKE_CYC cycles (computed like R2 from WAKE_MS) pass between the last falling `sck_o` edge of the 0x11 byte and the first rising edge of the next byte. `cs_n_o` is high throughout that gap.
- R6: Transfers use SPI mode 0, most significant bit first. `sck_o` idles low, `mosi_o` is stable while `sck_o` is high, and every high phase of `sck_o` lasts exactly HALF_DIV cycles.
- R7: `dc_o` does not change while a byte is being shifted, and `sck_o` is only high while `cs_n_o` is low.
- R8: `cs_n_o` frames the transfers. 0x11 is alone in one frame, 0x3A and its parameter share the next frame, and 0x29 is alone in a third frame. `cs_n_o` is high for at least one cycle between frames and stays high after the last one.
- R9: `busy_o` rises the cycle after start is accepted and falls in the cycle in which `done_o` rises, within 2 cycles of the last falling `sck_o` edge. `done_o` then holds until `rst_n`. The two flags are never high together.
- R10: A start request while busy or after done has no effect. No second panel reset pulse follows and no extra byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Request to run the power-up script |
| fmt18_i | input | 1 | Colour depth select: 1 = 18-bit, 0 = 16-bit |
| panel_rst_n_o | output | 1 | Active-low hardware reset to the panel |
| cs_n_o | output | 1 | Active-low chip select |
| dc_o | output | 1 | Data/command select: 0 = command, 1 = parameter |
| sck_o | output | 1 | Serial clock, mode 0 |
| mosi_o | output | 1 | Serial data out, MSB first |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Display-on byte has been sent |

## Verification
The start request and the end of the sequence can coincide. In one run `start_i` is held high across the whole sequence, including the cycle in which `done_o` rises, so a new request meets the completion edge. That run is judged by the count of panel reset pulses, the captured byte list staying at four, and `done_o` staying high afterwards. A second run pulses start again in the middle of the wake delay and flips `fmt18_i` at the same time. It is judged by the unchanged byte script and the originally sampled format parameter.

// File: rtl/pis_pkg.sv
package pis_pkg;

    localparam logic [7:0] CMD_WAKE  = 8'h11;
    localparam logic [7:0] CMD_PIXFMT = 8'h3A;
    localparam logic [7:0] PAR_RGB16 = 8'h55;
    localparam logic [7:0] PAR_RGB18 = 8'h66;
    localparam logic [7:0] CMD_DISPON = 8'h29;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_SETTLE,
        ST_WAKE_TX,
        ST_WAKE_WAIT,
        ST_FMT_CMD,
        ST_FMT_PAR,
        ST_FRAME_GAP,
        ST_ON_CMD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       fmt18;
        logic       issued;
        logic       prst_n;
        logic       cs_n;
    } ctl_regs_t;

endpackage

// File: rtl/pis_byte_tx.sv
module pis_byte_tx #(
    parameter int HALF_DIV = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       dc_i,
    output logic       active_o,
    output logic       done_o,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       dc_o
);

    localparam int DW = $clog2(HALF_DIV + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    typedef struct packed {
        logic [7:0]    sh;
        logic [2:0]    bitn;
        logic [DW-1:0] div;
        logic          sck;
        logic          active;
        logic          dc;
        logic          done;
    } tx_regs_t;

    tx_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (load_i) begin
                d.sh     = byte_i;
                d.dc     = dc_i;
                d.active = 1'b1;
                d.div    = '0;
                d.sck    = 1'b0;
                d.bitn   = '0;
            end
        end else if (q.div == DIV_LAST) begin
            d.div = '0;
            if (!q.sck) begin
                d.sck = 1'b1;
            end else begin
                d.sck = 1'b0;
                if (q.bitn == 3'd7) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end else begin
                    d.bitn = q.bitn + 3'd1;
                    d.sh   = {q.sh[6:0], 1'b0};
                end
            end
        end else begin
            d.div = q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active_o = q.active;
    assign done_o   = q.done;
    assign sck_o    = q.sck;
    assign mosi_o   = q.sh[7];
    assign dc_o     = q.dc;

endmodule

// File: rtl/pis_delay.sv
module pis_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          expired_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
        logic          exp;
    } dly_regs_t;

    dly_regs_t q, d;

    always_comb begin
        d     = q;
        d.exp = 1'b0;
        if (load_i) begin
            d.cnt = len_i;
            d.run = 1'b1;
        end else if (q.run) begin
            if (q.cnt <= CW'(1)) begin
                d.run = 1'b0;
                d.exp = 1'b1;
            end else begin
                d.cnt = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired_o = q.exp;

endmodule

// File: rtl/pis_ctrl.sv
module pis_ctrl
    import pis_pkg::*;
#(
    parameter int CW       = 8,
    parameter int RST_CYC  = 10,
    parameter int POST_CYC = 5,
    parameter int WAKE_CYC = 120
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          fmt18_i,
    input  logic          tx_done_i,
    input  logic          dly_exp_i,
    output logic          tx_load_o,
    output logic [7:0]    tx_byte_o,
    output logic          tx_dc_o,
    output logic          dly_load_o,
    output logic [CW-1:0] dly_len_o,
    output logic          panel_rst_n_o,
    output logic          cs_n_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam ctl_regs_t CTL_RESET = '{
        state:  ST_IDLE,
        fmt18:  1'b0,
        issued: 1'b0,
        prst_n: 1'b1,
        cs_n:   1'b1
    };

    ctl_regs_t q, d;
    logic      is_send;
    logic      is_wait;

    always_comb begin
        is_send = (q.state == ST_WAKE_TX) || (q.state == ST_FMT_CMD) ||
                  (q.state == ST_FMT_PAR) || (q.state == ST_ON_CMD);
        is_wait = (q.state == ST_RST_LOW) || (q.state == ST_RST_SETTLE) ||
                  (q.state == ST_WAKE_WAIT);

        tx_byte_o = CMD_WAKE;
        tx_dc_o   = 1'b0;
        unique case (q.state)
            ST_FMT_CMD: tx_byte_o = CMD_PIXFMT;
            ST_FMT_PAR: begin
                tx_byte_o = q.fmt18 ? PAR_RGB18 : PAR_RGB16;
                tx_dc_o   = 1'b1;
            end
            ST_ON_CMD:  tx_byte_o = CMD_DISPON;
            default:    tx_byte_o = CMD_WAKE;
        endcase

        dly_len_o = CW'(RST_CYC);
        if (q.state == ST_RST_SETTLE) dly_len_o = CW'(POST_CYC);
        if (q.state == ST_WAKE_WAIT)  dly_len_o = CW'(WAKE_CYC);

        tx_load_o  = is_send && !q.issued;
        dly_load_o = is_wait && !q.issued;

        d = q;
        if ((is_send || is_wait) && !q.issued) begin
            d.issued = 1'b1;
        end

        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state  = ST_RST_LOW;
                    d.fmt18  = fmt18_i;
                    d.prst_n = 1'b0;
                    d.issued = 1'b0;
                end
            end
            ST_RST_LOW: begin
                if (q.issued && dly_exp_i) begin
                    d.state  = ST_RST_SETTLE;
                    d.prst_n = 1'b1;
                    d.issued = 1'b0;
                end
            end
            ST_RST_SETTLE: begin
                if (q.issued && dly_exp_i) begin
                    d.state  = ST_WAKE_TX;
                    d.cs_n   = 1'b0;
                    d.issued = 1'b0;
                end
            end
            ST_WAKE_TX: begin
                if (q.issued && tx_done_i) begin
                    d.state  = ST_WAKE_WAIT;
                    d.cs_n   = 1'b1;
                    d.issued = 1'b0;
                end
            end
            ST_WAKE_WAIT: begin
                if (q.issued && dly_exp_i) begin
                    d.state  = ST_FMT_CMD;
                    d.cs_n   = 1'b0;
                    d.issued = 1'b0;
                end
            end
            ST_FMT_CMD: begin
                if (q.issued && tx_done_i) begin
                    d.state  = ST_FMT_PAR;
                    d.issued = 1'b0;
                end
            end
            ST_FMT_PAR: begin
                if (q.issued && tx_done_i) begin
                    d.state  = ST_FRAME_GAP;
                    d.cs_n   = 1'b1;
                    d.issued = 1'b0;
                end
            end
            ST_FRAME_GAP: begin
                d.state  = ST_ON_CMD;
                d.cs_n   = 1'b0;
                d.issued = 1'b0;
            end
            ST_ON_CMD: begin
                if (q.issued && tx_done_i) begin
                    d.state  = ST_DONE;
                    d.cs_n   = 1'b1;
                    d.issued = 1'b0;
                end
            end
            default: d.state = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RESET;
        else        q <= d;
    end

    assign panel_rst_n_o = q.prst_n;
    assign cs_n_o        = q.cs_n;
    assign busy_o        = (q.state != ST_IDLE) && (q.state != ST_DONE);
    assign done_o        = (q.state == ST_DONE);

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq #(
    parameter int CLK_HZ    = 100_000_000,
    parameter int HALF_DIV  = 3,
    parameter int DLY_SCALE = 1,
    parameter int RST_MS    = 10,
    parameter int POST_MS   = 5,
    parameter int WAKE_MS   = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fmt18_i,
    output logic panel_rst_n_o,
    output logic cs_n_o,
    output logic dc_o,
    output logic sck_o,
    output logic mosi_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CYC_MS   = CLK_HZ / 1000 / DLY_SCALE;
    localparam int RST_CYC  = RST_MS * CYC_MS;
    localparam int POST_CYC = POST_MS * CYC_MS;
    localparam int WAKE_CYC = WAKE_MS * CYC_MS;
    localparam int MAX_A    = (RST_CYC > POST_CYC) ? RST_CYC : POST_CYC;
    localparam int MAX_CYC  = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic          tx_load;
    logic [7:0]    tx_byte;
    logic          tx_dc;
    logic          tx_active;
    logic          tx_done;
    logic          dly_load;
    logic [CW-1:0] dly_len;
    logic          dly_exp;

    pis_ctrl #(
        .CW       (CW),
        .RST_CYC  (RST_CYC),
        .POST_CYC (POST_CYC),
        .WAKE_CYC (WAKE_CYC)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .fmt18_i       (fmt18_i),
        .tx_done_i     (tx_done),
        .dly_exp_i     (dly_exp),
        .tx_load_o     (tx_load),
        .tx_byte_o     (tx_byte),
        .tx_dc_o       (tx_dc),
        .dly_load_o    (dly_load),
        .dly_len_o     (dly_len),
        .panel_rst_n_o (panel_rst_n_o),
        .cs_n_o        (cs_n_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    pis_byte_tx #(
        .HALF_DIV (HALF_DIV)
    ) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tx_load),
        .byte_i   (tx_byte),
        .dc_i     (tx_dc),
        .active_o (tx_active),
        .done_o   (tx_done),
        .sck_o    (sck_o),
        .mosi_o   (mosi_o),
        .dc_o     (dc_o)
    );

    pis_delay #(
        .CW (CW)
    ) i_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (dly_load),
        .len_i     (dly_len),
        .expired_o (dly_exp)
    );

endmodule

// File: rtl/pis_checks.sv
module pis_checks (
    input logic clk,
    input logic rst_n,
    input logic panel_rst_n,
    input logic cs_n,
    input logic dc,
    input logic sck,
    input logic mosi,
    input logic busy,
    input logic done,
    input logic tx_active
);

    // R7: clock only toggles inside a chip-select frame
    a_r7_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    // R7: data/command level frozen while a byte shifts
    a_r7_dc_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && $past(tx_active)) |-> $stable(dc));

    // R6: data held while clock is high
    a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R6: clock idles low between bytes
    a_r6_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !sck);

    // R9: flags exclusive
    a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9: done sticks
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R2: link silent while panel is in reset
    a_r2_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> (cs_n && !sck));

endmodule

bind panel_init_seq pis_checks u_pis_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .panel_rst_n (panel_rst_n_o),
    .cs_n        (cs_n_o),
    .dc          (dc_o),
    .sck         (sck_o),
    .mosi        (mosi_o),
    .busy        (busy_o),
    .done        (done_o),
    .tx_active   (tx_active)
);

// File: tb/test_panel_init_seq.sv
`timescale 1ns/1ps
module test_panel_init_seq;

    localparam int CLK_HZ = 20000;
    localparam int HALF   = 2;
    localparam int CYC_MS = CLK_HZ / 1000;
    localparam int RSTC   = 10 * CYC_MS;
    localparam int POSTC  = 5 * CYC_MS;
    localparam int WAKEC  = 120 * CYC_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic fmt18 = 1'b0;
    logic prst_n, cs_n, dc, sck, mosi, busy, done;

    always #2 clk = ~clk;

    panel_init_seq #(
        .CLK_HZ   (CLK_HZ),
        .HALF_DIV (HALF)
    ) i_panel_init_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .fmt18_i       (fmt18),
        .panel_rst_n_o (prst_n),
        .cs_n_o        (cs_n),
        .dc_o          (dc),
        .sck_o         (sck),
        .mosi_o        (mosi),
        .busy_o        (busy),
        .done_o        (done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor state
    logic       mon_clr = 1'b0;
    logic       p_sck, p_cs, p_prst, p_busy;
    int         nb, bitn, frame, rst_falls, rst_low, sck_hi;
    int         t_prst_rise, t_cs_fall, t_b0_end, t_b1_start, t_done, t_last_fall;
    logic [7:0] shv;
    logic       dc0;
    logic [7:0] cap_b [8];
    logic       cap_dc[8];
    int         cap_fr[8];
    int         m_fail;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            nb = 0; bitn = 0; frame = 0; rst_falls = 0; rst_low = 0; sck_hi = 0;
            t_prst_rise = -1; t_cs_fall = -1; t_b0_end = -1; t_b1_start = -1;
            t_done = -1; t_last_fall = -1; m_fail = 0;
            p_sck = sck; p_cs = cs_n; p_prst = prst_n; p_busy = busy;
        end else begin
            if (!prst_n) rst_low++;
            if (p_prst && !prst_n) rst_falls++;
            if (!p_prst && prst_n && t_prst_rise < 0) t_prst_rise = cyc;
            if (p_cs && !cs_n && t_cs_fall < 0) t_cs_fall = cyc;
            if (!p_cs && cs_n) frame++;
            if (sck) sck_hi++;
            if (sck && cs_n) begin
                m_fail++;
                chk(0, "R7 sck high outside frame", 1, 0);
            end
            if (!p_sck && sck) begin
                if (bitn == 0) begin
                    dc0 = dc;
                    if (nb == 1 && t_b1_start < 0) t_b1_start = cyc;
                end else if (dc != dc0) begin
                    chk(0, "R7 dc changed mid-byte", int'(dc), int'(dc0));
                end
                shv = {shv[6:0], mosi};
                bitn++;
                if (bitn == 8) begin
                    if (nb < 8) begin
                        cap_b[nb] = shv; cap_dc[nb] = dc0; cap_fr[nb] = frame;
                    end
                    nb++;
                    bitn = 0;
                end
            end
            if (p_sck && !sck) begin
                if (sck_hi != HALF) chk(0, "R6 sck high phase length", sck_hi, HALF);
                sck_hi = 0;
                t_last_fall = cyc;
                if (nb == 1 && bitn == 0 && t_b0_end < 0) t_b0_end = cyc;
            end
            if (busy && done) chk(0, "R9 busy and done together", 1, 0);
            if (p_busy && !busy && !done) chk(0, "R9 busy fell without done", 0, 1);
            if (done && t_done < 0) t_done = cyc;
            p_sck = sck; p_cs = cs_n; p_prst = prst_n; p_busy = busy;
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // mode 0: plain pulse; 1: restart and format flip mid-wake; 2: start held high
    task automatic run_seq(input logic f, input int mode);
        logic [7:0] exp_par;
        exp_par = f ? 8'h66 : 8'h55;
        rst_n = 1'b0; start = 1'b0; fmt18 = f; mon_clr = 1'b1;
        tick(3);
        chk(prst_n && cs_n && !sck && !busy && !done, "R1 state in reset",
            {prst_n, cs_n, sck, busy, done}, 5'b11000);
        rst_n = 1'b1;
        tick(2);
        mon_clr = 1'b0;
        chk(prst_n && cs_n && !sck && !busy && !done, "R1 state after release",
            {prst_n, cs_n, sck, busy, done}, 5'b11000);
        start = 1'b1;
        tick(1);
        if (mode != 2) start = 1'b0;
        tick(1);
        chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);
        if (mode == 1) begin
            tick(RSTC + POSTC + 40 * HALF + 500);
            start = 1'b1; fmt18 = ~f;
            tick(1);
            start = 1'b0;
        end
        for (int i = 0; i < 20000 && !done; i++) tick(1);
        tick(10);
        if (mode == 2) begin
            chk(done === 1'b1, "R10 done with start held", int'(done), 1);
            start = 1'b0;
        end
        chk(done === 1'b1, "R9 done raised", int'(done), 1);
        chk(rst_low >= RSTC && rst_low <= RSTC + 2, "R2 reset low length", rst_low, RSTC);
        chk(t_cs_fall - t_prst_rise >= POSTC, "R2 settle after reset",
            t_cs_fall - t_prst_rise, POSTC);
        chk(nb == 4, "R3 byte count", nb, 4);
        chk(cap_b[0] == 8'h11 && cap_dc[0] == 1'b0, "R3 byte0 wake", cap_b[0], 8'h11);
        chk(cap_b[1] == 8'h3A && cap_dc[1] == 1'b0, "R3 byte1 format cmd", cap_b[1], 8'h3A);
        chk(cap_dc[2] == 1'b1, "R3 byte2 is parameter", int'(cap_dc[2]), 1);
        chk(cap_b[2] == exp_par, "R4 format parameter", cap_b[2], exp_par);
        chk(cap_b[3] == 8'h29 && cap_dc[3] == 1'b0, "R3 byte3 display on", cap_b[3], 8'h29);
        chk(t_b1_start - t_b0_end >= WAKEC, "R5 wake delay", t_b1_start - t_b0_end, WAKEC);
        chk(cap_fr[0] == 0 && cap_fr[1] == 1 && cap_fr[2] == 1 && cap_fr[3] == 2,
            "R8 frame grouping", cap_fr[3], 2);
        chk(frame == 3 && cs_n, "R8 cs high after last frame", frame, 3);
        chk(t_done - t_last_fall <= 2 && t_done >= t_last_fall, "R9 done timing",
            t_done - t_last_fall, 1);
        // R10: start after done is ignored
        start = 1'b1;
        tick(1);
        start = 1'b0;
        tick(300);
        chk(nb == 4 && rst_falls == 1, "R10 start after done ignored", nb, 4);
        chk(done && !busy, "R9 done held", int'(done), 1);
        chk(rst_falls == 1, "R10 single reset pulse", rst_falls, 1);
    endtask

    initial begin
        mon_clr = 1'b1;
        run_seq(1'b0, 0);
        run_seq(1'b1, 0);
        run_seq(1'b0, 1);
        run_seq(1'b1, 1);
        run_seq(1'b1, 2);
        run_seq(1'b0, 2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule